// File: doc/BRIEF.md
# Transceiver Heartbeat Self-Test Monitor

An Ethernet transceiver with a signal-quality-error self-test shows that it is healthy by raising its collision line shortly after the MAC ends a transmitted frame. This block watches for that pulse. Each frame-complete strobe opens a timed window that covers 4 microseconds at the collision pin. A collision seen inside the window counts as a passed self-test, not as a network fault, and the window closes. If the window runs out with no collision seen, the block latches a heartbeat error.

The whole check runs only while a check-enable input is high. The error flag is sticky. Software clears it by writing a one, which reaches the block as a single-cycle clear strobe. The interrupt output follows the flag only while the interrupt-mask input allows it. If a new frame starts while a window is still open, that window closes quietly.

The collision input is asynchronous and passes through a synchroniser before it is used. The window length is computed at elaboration from the clock frequency, and the synchroniser latency is added to it.

Top module: `hb_sqe_monitor`

## Requirements
- R1: After reset, `err_o` and `irq_o` are 0.
- R2: With `chk_en_i` high, let `frame_done_i` be sampled high at clock edge k, and let BASE = ceil(CLK_FREQ_HZ * WINDOW_NS / 1e9). A collision held high for one cycle, sampled at edge k+d with 0 <= d <= BASE, prevents the error. A collision at d > BASE, or no collision at all, does not prevent it.
- R3: When no collision arrives, `err_o` rises exactly after edge k+BASE+SYNC_STAGES and not before.
- R4: While `chk_en_i` is low, frame-complete strobes open no window. Dropping `chk_en_i` while a window is open closes that window without an error.
- R5: `irq_o` is high exactly when `err_o` is high and `irq_mask_i` is 1.
- R6: `err_o` stays high until `err_clr_i` is sampled high. It then reads 0 after that edge, provided no error is raised at the same edge.
- R7: If an expiry and `err_clr_i` fall on the same edge, the expiry wins and `err_o` stays 1.
- R8: `tx_start_i` sampled high while a window is open closes the window without an error.
- R9: A collision that arrives while no window is open has no effect. It does not pass a window that opens later.
- R10: A frame-complete strobe that arrives while a window is open restarts the full window from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_done_i | input | 1 | One-cycle strobe when a transmitted frame ends |
| tx_start_i | input | 1 | One-cycle strobe when a new frame starts |
| col_i | input | 1 | Collision indication from the transceiver, asynchronous |
| chk_en_i | input | 1 | Heartbeat check enable |
| irq_mask_i | input | 1 | 1 lets the error drive the interrupt |
| err_clr_i | input | 1 | Write-one-to-clear strobe for the error flag |
| err_o | output | 1 | Sticky heartbeat error flag |
| irq_o | output | 1 | Heartbeat interrupt |

## Verification
A wrong count in the window timer shows at the ports as an error edge that lands one or more cycles away from edge k+BASE+SYNC_STAGES. It also moves the collision offset that still passes the check away from BASE. Both can be seen in the frame in which the fault occurs. A window state that is stuck open or wrongly closed shows up in the same frame, either as a missing error or as a collision that passes when it should not. A faulty flag register shows on the first clear or the first idle cycle after an error.

// File: rtl/hb_sqe_pkg.sv
package hb_sqe_pkg;

   typedef enum logic {
      WIN_IDLE = 1'b0,
      WIN_OPEN = 1'b1
   } win_state_e;

   // Number of clock cycles that covers win_ns at clk_hz, rounded up.
   function automatic longint calc_win_cycles(input longint clk_hz, input longint win_ns);
      longint prod;
      prod = clk_hz * win_ns;
      return (prod + 64'd999_999_999) / 64'd1_000_000_000;
   endfunction

endpackage

// File: rtl/hb_sync_chain.sv
module hb_sync_chain #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign sync_o = async_i;
      end else begin : g_chain
         logic [STAGES-1:0] stage_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               stage_q <= '0;
            end else begin
               stage_q[0] <= async_i;
               for (int s = 1; s < STAGES; s++) begin
                  stage_q[s] <= stage_q[s-1];
               end
            end
         end
         assign sync_o = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/hb_win_timer.sv
module hb_win_timer
   import hb_sqe_pkg::*;
#(
   parameter int WIN_CYCLES = 402,
   localparam int CW = $clog2(WIN_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic abort_i,
   input  logic col_i,
   output logic open_o,
   output logic expire_o
);

   localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

   win_state_e    state_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= WIN_IDLE;
         cnt_q   <= '0;
      end else if (start_i) begin
         state_q <= WIN_OPEN;
         cnt_q   <= LAST;
      end else if (state_q == WIN_OPEN) begin
         if (abort_i || col_i || cnt_q == '0) begin
            state_q <= WIN_IDLE;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign open_o   = (state_q == WIN_OPEN);
   assign expire_o = (state_q == WIN_OPEN) && !start_i && !abort_i
                     && !col_i && (cnt_q == '0);

endmodule

// File: rtl/hb_err_flag.sv
module hb_err_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic mask_i,
   output logic err_o,
   output logic irq_o
);

   logic err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else if (set_i) begin
         err_q <= 1'b1;
      end else if (clr_i) begin
         err_q <= 1'b0;
      end
   end

   assign err_o = err_q;
   assign irq_o = err_q & mask_i;

endmodule

// File: rtl/hb_sqe_monitor.sv
module hb_sqe_monitor
   import hb_sqe_pkg::*;
#(
   parameter longint CLK_FREQ_HZ = 100_000_000,
   parameter longint WINDOW_NS   = 4000,
   parameter int     SYNC_STAGES = 2,
   localparam int    BASE_CYCLES = int'(calc_win_cycles(CLK_FREQ_HZ, WINDOW_NS)),
   localparam int    WIN_CYCLES  = BASE_CYCLES + SYNC_STAGES
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_done_i,
   input  logic tx_start_i,
   input  logic col_i,
   input  logic chk_en_i,
   input  logic irq_mask_i,
   input  logic err_clr_i,
   output logic err_o,
   output logic irq_o
);

   generate
      if (CLK_FREQ_HZ < 1) begin : g_bad_clk
         $error("CLK_FREQ_HZ must be positive");
      end
      if (WINDOW_NS < 1) begin : g_bad_win
         $error("WINDOW_NS must be positive");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be in 0..4");
      end
   endgenerate

   logic col_sync;
   logic win_start;
   logic win_abort;
   logic win_open;
   logic win_expire;

   hb_sync_chain #(
      .STAGES(SYNC_STAGES)
   ) sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(col_i),
      .sync_o (col_sync)
   );

   assign win_start = frame_done_i & chk_en_i;
   assign win_abort = tx_start_i | ~chk_en_i;

   hb_win_timer #(
      .WIN_CYCLES(WIN_CYCLES)
   ) timer_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (win_start),
      .abort_i (win_abort),
      .col_i   (col_sync),
      .open_o  (win_open),
      .expire_o(win_expire)
   );

   hb_err_flag flag_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (win_expire),
      .clr_i (err_clr_i),
      .mask_i(irq_mask_i),
      .err_o (err_o),
      .irq_o (irq_o)
   );

endmodule

module hb_sqe_monitor_chk (
   input logic clk,
   input logic rst_n,
   input logic frame_done_i,
   input logic tx_start_i,
   input logic chk_en_i,
   input logic err_clr_i,
   input logic col_sync,
   input logic win_open,
   input logic win_expire,
   input logic err_o,
   input logic irq_o
);

   // R3
   err_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> $past(win_expire));

   // R2
   expire_nocol_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_expire |-> !col_sync);

   // R4
   disabled_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_en_i |=> !win_open);

   // R6
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o && !err_clr_i |=> err_o);

   // R5
   irq_needs_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> err_o);

   // R8
   start_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start_i && win_open && !frame_done_i |=> !win_open);

   // R7
   set_over_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_expire && err_clr_i |=> err_o);

endmodule

bind hb_sqe_monitor hb_sqe_monitor_chk chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_done_i(frame_done_i),
   .tx_start_i  (tx_start_i),
   .chk_en_i    (chk_en_i),
   .err_clr_i   (err_clr_i),
   .col_sync    (col_sync),
   .win_open    (win_open),
   .win_expire  (win_expire),
   .err_o       (err_o),
   .irq_o       (irq_o)
);

// File: tb/hb_sqe_monitor_tb_top.sv
module hb_sqe_monitor_tb_top;

   localparam longint FREQ = 4_000_000;
   localparam longint WNS  = 4000;
   localparam int     SYNC = 2;
   localparam int     BASE = int'((FREQ * WNS + 999_999_999) / 1_000_000_000);
   localparam int     WIN  = BASE + SYNC;
   localparam int     NONE = 1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_done_i = 1'b0;
   logic tx_start_i = 1'b0;
   logic col_i = 1'b0;
   logic chk_en_i = 1'b1;
   logic irq_mask_i = 1'b0;
   logic err_clr_i = 1'b0;
   logic err_o;
   logic irq_o;

   int checks = 0;
   int errors = 0;
   logic hist [0:63];

   always #5 clk = ~clk;

   hb_sqe_monitor #(
      .CLK_FREQ_HZ(FREQ),
      .WINDOW_NS  (WNS),
      .SYNC_STAGES(SYNC)
   ) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_done_i(frame_done_i),
      .tx_start_i  (tx_start_i),
      .col_i       (col_i),
      .chk_en_i    (chk_en_i),
      .irq_mask_i  (irq_mask_i),
      .err_clr_i   (err_clr_i),
      .err_o       (err_o),
      .irq_o       (irq_o)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic clear_err();
      err_clr_i = 1'b1;
      @(negedge clk);
      err_clr_i = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   // Step i drives the inputs sampled at edge k+i; hist[i] holds err_o after that edge.
   task automatic run_frame(input int col_at, input int abort_at, input int refr_at,
                            input int clr_at, input int len);
      for (int i = 0; i < len; i++) begin
         frame_done_i = (i == 0) || (i == refr_at);
         col_i        = (i == col_at);
         tx_start_i   = (i == abort_at);
         err_clr_i    = (i == clr_at);
         @(negedge clk);
         hist[i] = err_o;
      end
      frame_done_i = 1'b0;
      col_i        = 1'b0;
      tx_start_i   = 1'b0;
      err_clr_i    = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (200_000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1
      check("R1 err", err_o, 1'b0);
      check("R1 irq", irq_o, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 sweep of the collision offset across the window edge
      for (int d = 0; d <= BASE + 4; d++) begin
         run_frame(d, NONE, NONE, NONE, WIN + 4);
         check($sformatf("R2 offset %0d", d), err_o, (d > BASE));
         clear_err();
      end

      // R3 exact cycle of the error edge
      run_frame(NONE, NONE, NONE, NONE, WIN + 2);
      check("R3 before expiry", hist[WIN-2], 1'b0);
      check("R3 at expiry", hist[WIN-1], 1'b0);
      check("R3 after expiry", hist[WIN], 1'b1);

      // R5 mask gating
      irq_mask_i = 1'b0;
      #1 check("R5 masked", irq_o, 1'b0);
      irq_mask_i = 1'b1;
      #1 check("R5 unmasked", irq_o, 1'b1);

      // R6 sticky through a passing frame, then cleared
      run_frame(3, NONE, NONE, NONE, WIN + 4);
      check("R6 sticky", err_o, 1'b1);
      clear_err();
      check("R6 cleared", err_o, 1'b0);
      check("R5 irq follows clear", irq_o, 1'b0);
      irq_mask_i = 1'b0;

      // R7 expiry and clear on the same edge
      run_frame(NONE, NONE, NONE, WIN, WIN + 2);
      check("R7 set wins", err_o, 1'b1);
      clear_err();

      // R4 check disabled
      chk_en_i = 1'b0;
      run_frame(NONE, NONE, NONE, NONE, WIN + 4);
      check("R4 disabled", err_o, 1'b0);
      chk_en_i = 1'b1;
      frame_done_i = 1'b1;
      @(negedge clk);
      frame_done_i = 1'b0;
      repeat (4) @(negedge clk);
      chk_en_i = 1'b0;
      repeat (WIN + 4) @(negedge clk);
      check("R4 drop closes window", err_o, 1'b0);
      chk_en_i = 1'b1;
      repeat (2) @(negedge clk);

      // R8 new frame aborts window
      run_frame(NONE, 5, NONE, NONE, WIN + 4);
      check("R8 aborted", err_o, 1'b0);

      // R9 stray collision before the window does not pass it
      col_i = 1'b1;
      @(negedge clk);
      col_i = 1'b0;
      repeat (8) @(negedge clk);
      check("R9 stray no error", err_o, 1'b0);
      run_frame(NONE, NONE, NONE, NONE, WIN + 4);
      check("R9 later window fails", err_o, 1'b1);
      clear_err();

      // R10 restart on a second strobe
      run_frame(NONE, NONE, 10, NONE, WIN + 14);
      check("R10 no error at first end", hist[WIN], 1'b0);
      check("R10 no error before restart end", hist[WIN+9], 1'b0);
      check("R10 error at restarted end", hist[WIN+10], 1'b1);
      clear_err();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule